// File: doc/BRIEF.md
# Page Frame Assembler for Flash Programming

This block gathers a byte stream carrying a new configuration image into page-sized frames for an SPI NOR flash page-program engine. The bytes of one frame go into an internal page buffer. When a frame closes, the block raises a one-clock frame-ready pulse. It also presents the frame's byte count and a page-aligned 24-bit target address. These values stay on the outputs until the program engine acknowledges the frame. While that frame waits, the engine reads the buffer through a synchronous read port, and the block refuses new input bytes.

A frame closes in one of three ways: a full page has arrived, a byte arrives flagged as the last byte of the image, or an end-of-image strobe arrives with no byte. Every frame is a full page except the final one, which holds only the bytes that remain. Target addresses start at zero and advance by one page for each closed frame. An erase-start request, issued before the image is written into a freshly erased chip, returns the next target address to zero. An end-of-image strobe that finds no bytes collected produces no frame; the block gives a separate image-done pulse instead.

Top module: `pgframe_asm`

## Requirements
- R1: After reset, in_ready is 1, frm_ready and img_done are 0, and frm_len, frm_addr and rd_data are all 0.
- R2: A byte is accepted on a clock edge where in_valid and in_ready are both 1. On the edge that accepts the 256th byte of a frame, the frame closes. In the following cycle frm_ready is 1 and frm_len is 256.
- R3: A byte accepted with in_last set closes the frame on that edge. frm_len then equals the number of bytes accepted in the frame, which is from 1 to 256.
- R4: The target address is page aligned, so bits [7:0] of frm_addr are zero. The first frame after reset or erase targets 0x000000. Each later frame targets the previous frame's address plus 0x000100, wrapping at 24 bits.
- R5: An erase_req edge sets the next target address to 0x000000. A frame that closes on that same edge keeps the address it had before the erase, and the frame after it targets 0x000000.
- R6: From the cycle in which frm_ready pulses until a frame is acknowledged, in_ready is 0, in_valid has no effect, and frm_len and frm_addr stay constant.
- R7: frm_ack during a pending frame makes in_ready 1 in the next cycle and starts an empty frame. frm_ack while no frame is pending has no effect.
- R8: rd_en at an edge loads rd_data with the byte stored at offset rd_idx of the current frame, visible in the next cycle. Offset 0 is the first byte received. Without rd_en, rd_data holds its value.
- R9: img_end closes a partly filled frame as a short frame, unless a byte accepted on the same edge already closed the frame. img_end with no bytes collected gives a one-cycle img_done pulse and no frm_ready. img_end while a frame is pending is ignored.
- R10: frm_ready is never high for two consecutive cycles, and it is never high in the same cycle as img_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the final byte of the image |
| in_ready | output | 1 | Block can accept a byte |
| img_end | input | 1 | End of image without a byte |
| erase_req | input | 1 | Erase started; next target address returns to zero |
| frm_ready | output | 1 | One-cycle pulse: a frame is complete |
| frm_len | output | 16 | Byte count of the pending frame |
| frm_addr | output | 24 | Page-aligned target address of the pending frame |
| frm_ack | input | 1 | Program engine has consumed the frame |
| img_done | output | 1 | One-cycle pulse: image ended with no bytes left to program |
| rd_en | input | 1 | Buffer read strobe |
| rd_idx | input | 8 | Byte offset within the frame to read |
| rd_data | output | 8 | Byte read from the buffer, one cycle after rd_en |

## Verification
The assertions check, on every cycle, the properties that need only the pins: frm_ready is a lone pulse and never coincides with img_done, the input is held off while a frame is pending, length and address stay frozen until the acknowledge, an acknowledge reopens the input, and every reported address is page aligned with a length in range. Only the bench's scenarios can show the counting itself: that a frame closes exactly on the 256th byte or on the flagged byte, that addresses advance page by page and return to zero after an erase (also on the edge where a frame closes), that the bytes read back match the bytes sent, and that end-of-image strobes behave as specified in each state.

// File: rtl/pgfa_pkg.sv
package pgfa_pkg;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_HOLD = 1'b1
    } fill_state_e;

endpackage

// File: rtl/pgfa_buf.sv
// Page buffer: one write port for incoming bytes, one synchronous read port
module pgfa_buf #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = mem_q[rd_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/pgfa_addr.sv
// Target address generator: page steps, cleared by erase
module pgfa_addr #(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              erase,
    output logic [ADDR_W-1:0] frm_addr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PAGE_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] next;
        logic [ADDR_W-1:0] cur;
    } addr_t;

    addr_t addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (advance) begin
            addr_d.cur  = addr_q.next;
            addr_d.next = addr_q.next + STEP;
        end
        if (erase) begin
            addr_d.next = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign frm_addr = addr_q.cur;

endmodule

// File: rtl/pgfa_ctrl.sv
// Fill/hold sequencer: counts bytes, closes frames, produces pulses
module pgfa_ctrl
    import pgfa_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int LEN_W      = 16,
    localparam int IDX_W     = $clog2(PAGE_BYTES),
    localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             img_end,
    input  logic             frm_ack,
    output logic             in_ready,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             close,
    output logic             frm_ready,
    output logic [LEN_W-1:0] frm_len,
    output logic             img_done
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        fill_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic             rdy;
        logic             done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic             accept;
    logic [CNT_W-1:0] cnt_after;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.rdy  = 1'b0;
        ctrl_d.done = 1'b0;
        close       = 1'b0;
        accept      = (ctrl_q.st == ST_FILL) && in_valid;
        cnt_after   = ctrl_q.cnt + CNT_W'(accept);
        wr_en       = accept;

        unique case (ctrl_q.st)
            ST_FILL: begin
                if (accept && (in_last || cnt_after == FULL)) begin
                    close = 1'b1;
                end else if (img_end) begin
                    if (cnt_after == '0) begin
                        ctrl_d.done = 1'b1;
                    end else begin
                        close = 1'b1;
                    end
                end
                ctrl_d.cnt = cnt_after;
                if (close) begin
                    ctrl_d.st  = ST_HOLD;
                    ctrl_d.len = LEN_W'(cnt_after);
                    ctrl_d.rdy = 1'b1;
                end
            end
            ST_HOLD: begin
                if (frm_ack) begin
                    ctrl_d.st  = ST_FILL;
                    ctrl_d.cnt = '0;
                end
            end
            default: ctrl_d.st = ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_FILL, cnt: '0, len: '0, rdy: 1'b0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign in_ready  = (ctrl_q.st == ST_FILL);
    assign wr_idx    = ctrl_q.cnt[IDX_W-1:0];
    assign frm_ready = ctrl_q.rdy;
    assign frm_len   = ctrl_q.len;
    assign img_done  = ctrl_q.done;

endmodule

// File: rtl/pgframe_asm.sv
module pgframe_asm #(
    parameter int PAGE_BYTES = 256,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              img_end,
    input  logic              erase_req,
    output logic              frm_ready,
    output logic [LEN_W-1:0]  frm_len,
    output logic [ADDR_W-1:0] frm_addr,
    input  logic              frm_ack,
    output logic              img_done,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             close;

    pgfa_ctrl #(
        .PAGE_BYTES(PAGE_BYTES),
        .LEN_W     (LEN_W)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_last  (in_last),
        .img_end  (img_end),
        .frm_ack  (frm_ack),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .close    (close),
        .frm_ready(frm_ready),
        .frm_len  (frm_len),
        .img_done (img_done)
    );

    pgfa_addr #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) i_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (close),
        .erase   (erase_req),
        .frm_addr(frm_addr)
    );

    pgfa_buf #(
        .DEPTH (PAGE_BYTES),
        .DATA_W(DATA_W)
    ) i_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(in_data),
        .rd_en  (rd_en),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/pgfa_chk.sv
module pgfa_chk #(
    parameter int PAGE_BYTES = 256,
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              frm_ack,
    input logic              frm_ready,
    input logic [LEN_W-1:0]  frm_len,
    input logic [ADDR_W-1:0] frm_addr,
    input logic              img_done
);

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ready |=> !frm_ready);

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_ready && img_done));

    p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ready |-> !in_ready);

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !frm_ack) |=> (!in_ready && $stable(frm_len) && $stable(frm_addr)));

    p_reopen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && frm_ack) |=> in_ready);

    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ready |-> (frm_addr[IDX_W-1:0] == '0));

    p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ready |-> (frm_len >= LEN_W'(1) && frm_len <= LEN_W'(PAGE_BYTES)));

endmodule

bind pgframe_asm pgfa_chk #(
    .PAGE_BYTES(PAGE_BYTES),
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W)
) i_pgfa_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .frm_ack  (frm_ack),
    .frm_ready(frm_ready),
    .frm_len  (frm_len),
    .frm_addr (frm_addr),
    .img_done (img_done)
);

// File: tb/test_pgframe_asm.sv
`timescale 1ns/1ps
module test_pgframe_asm;

    localparam int PAGE = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        img_end = 1'b0;
    logic        erase_req = 1'b0;
    logic        frm_ack = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_idx = 8'h00;
    logic        in_ready, frm_ready, img_done;
    logic [15:0] frm_len;
    logic [23:0] frm_addr;
    logic [7:0]  rd_data;

    always #2.5 clk = ~clk;

    pgframe_asm i_pgframe_asm (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .img_end(img_end), .erase_req(erase_req),
        .frm_ready(frm_ready), .frm_len(frm_len), .frm_addr(frm_addr), .frm_ack(frm_ack),
        .img_done(img_done), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // behavioural reference
    logic [7:0]  m_mem [PAGE];
    int          m_cnt = 0;
    bit          m_pend = 0;
    bit          m_rdy = 0;
    bit          m_done = 0;
    int          m_len = 0;
    logic [23:0] m_addr = 0;
    logic [23:0] m_next = 0;
    logic [7:0]  m_rd = 0;

    int    vectors = 0;
    int    miscompares = 0;
    bit    finished = 0;
    string cur_req = "R1";

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    task automatic model();
        bit closed = 0;
        m_rdy  = 0;
        m_done = 0;
        if (rd_en) m_rd = m_mem[rd_idx];
        if (!m_pend) begin
            if (in_valid) begin
                m_mem[m_cnt] = in_data;
                m_cnt++;
                if (in_last || m_cnt == PAGE) closed = 1;
            end
            if (!closed && img_end) begin
                if (m_cnt == 0) m_done = 1;
                else closed = 1;
            end
            if (closed) begin
                m_pend = 1;
                m_len  = m_cnt;
                m_addr = m_next;
                m_next = m_next + 24'(PAGE);
                m_rdy  = 1;
            end
        end else if (frm_ack) begin
            m_pend = 0;
            m_cnt  = 0;
        end
        if (erase_req) m_next = 0;
    endtask

    task automatic chk(string what, longint act, longint exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        vectors++;
        chk("in_ready",  in_ready,  !m_pend);
        chk("frm_ready", frm_ready, m_rdy);
        chk("img_done",  img_done,  m_done);
        chk("frm_len",   frm_len,   m_len);
        chk("frm_addr",  frm_addr,  m_addr);
        chk("rd_data",   rd_data,   m_rd);
    endtask

    task automatic idle();
        in_valid = 0; in_last = 0; img_end = 0; erase_req = 0;
        frm_ack = 0; rd_en = 0;
    endtask

    // inputs set at negedge; one tick = edge, model update, compare
    task automatic tick();
        @(posedge clk);
        model();
        @(negedge clk);
        compare();
        idle();
    endtask

    // send n bytes starting at value seed; last flag on the final byte if asked
    task automatic send(int n, int seed, bit with_last, bit gaps);
        int i = 0;
        while (i < n) begin
            if (gaps && (i % 7 == 3)) begin
                tick();
            end
            in_valid = 1;
            in_data  = 8'(seed + i * 3);
            in_last  = with_last && (i == n - 1);
            tick();
            i++;
        end
    endtask

    task automatic read_at(int idx);
        rd_en  = 1;
        rd_idx = 8'(idx);
        tick();
    endtask

    task automatic ack();
        frm_ack = 1;
        tick();
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        compare();
        tick();

        // R2 full page with stalls; R10 pulse width; R6 input held off
        cur_req = "R2";
        send(PAGE, 5, 0, 1);
        cur_req = "R10";
        tick();
        cur_req = "R6";
        for (int k = 0; k < 4; k++) begin
            in_valid = 1; in_data = 8'hEE; in_last = 1;
            tick();
        end
        // R8 read back
        cur_req = "R8";
        read_at(0); read_at(1); read_at(255); read_at(128);
        tick();
        // R7 acknowledge, then stray acknowledge
        cur_req = "R7";
        ack();
        ack();
        read_at(0);

        // R4 second full page at next address
        cur_req = "R4";
        send(PAGE, 9, 0, 0);
        tick();
        ack();

        // R3 short frame via last flag
        cur_req = "R3";
        send(5, 40, 1, 0);
        tick();
        read_at(4); read_at(0);
        ack();

        // R9 image end after three bytes, without a byte
        cur_req = "R9";
        send(3, 77, 0, 0);
        img_end = 1;
        tick();
        tick();
        img_end = 1;          // ignored while pending
        tick();
        read_at(2);
        ack();
        img_end = 1;          // nothing collected: done pulse
        tick();
        tick();
        in_valid = 1; in_data = 8'h5A; img_end = 1;  // byte plus end closes a 1-byte frame
        tick();
        tick();
        ack();

        // R5 erase, then frames restart at zero
        cur_req = "R5";
        erase_req = 1;
        tick();
        send(1, 3, 1, 0);
        tick();
        ack();
        send(3, 8, 0, 0);
        in_valid = 1; in_data = 8'h11; in_last = 1; erase_req = 1;  // close and erase together
        tick();
        tick();
        ack();
        send(2, 21, 1, 0);
        tick();
        read_at(1);
        ack();

        // R2 full page ending with last flag on the 256th byte
        cur_req = "R2";
        send(PAGE, 100, 1, 1);
        tick();
        read_at(200);
        ack();
        repeat (4) tick();

        report();
    end

    initial begin
        #(5.0 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule